// File: doc/BRIEF.md
# Event Capture/Compare Channel with Up/Down Timer

This block pairs one 16-bit timer/counter with one event channel that works either as a capture unit or as a compare unit. The timer advances by one on every clock cycle, or it follows an external clock pin. In that case every edge of the pin, rising or falling, moves the count by one, and a separate direction pin picks up or down. Both external pins, and the capture pin, pass through a two-stage synchronizer and an edge detector before they are used.

In capture mode a chosen edge on the capture pin copies the timer value into a two-entry buffer. Software can then read two captures in arrival order. When a capture arrives while both entries are full, the block raises a sticky overrun flag. A control bit then picks one of two actions: the newest value replaces the second entry, or the newest value is dropped. In both cases the channel keeps accepting captures once it has been read.

In compare mode the block pulses a match output when the timer counts onto the programmed value. Loading or clearing the timer onto that value never counts as a match. An interrupt output pulses on each match and on each capture event.

The capture buffer is a three-state machine:
- `CAP_EMPTY` goes to `CAP_ONE` on a capture.
- `CAP_ONE` goes to `CAP_TWO` on a capture without a read, and back to `CAP_EMPTY` on a read without a capture. A capture and a read in the same cycle keep it in `CAP_ONE` and replace the head.
- `CAP_TWO` goes to `CAP_ONE` on a read without a capture. A read with a capture shifts the buffer and stays in `CAP_TWO`. A capture without a read is the overrun case, which stays in `CAP_TWO`.

Top module: `evcc_top`

## Requirements
- R1: Reset values.
  - After reset the timer, the compare value and the control word are zero and the buffer is empty.
  - A read of register 3 returns zero, and `match_o` and `irq_o` are low.
- R2: Internal clock mode.
  - With control bit 5 (run) set and bit 0 (external clock) clear, the timer rises by one per clock cycle and wraps from FFFF to 0000.
  - With run clear the timer holds its value.
  - The register map is:
    - address 0: control in bits 5:0, status in bits 10:8
    - address 1: timer
    - address 2: compare value
    - address 3: capture head
- R3: External clock mode.
  - With run and bit 0 set, each rising edge and each falling edge of `ext_clk` moves the timer by one. The count goes up when `ext_dir` is high and down when it is low.
  - The new value is readable three clock edges after the pin changes.
  - Internal cycles do not count in this mode.
- R4: Compare match.
  - With bit 1 (compare mode) set, `match_o` pulses high for exactly one cycle, one cycle after the timer counts onto the compare value.
- R5: Writing the timer with a value equal to the compare value never produces a match, whether the timer is stopped or running.
- R6: Timer clear.
  - Pulsing `tmr_clr` sets the timer to zero without a match, even when the compare value is zero.
  - When `tmr_clr` and a timer write fall in the same cycle, the clear wins.
- R7: Capture edge select.
  - Control bits 3:2 pick the capture edge: 00 none, 01 rising, 10 falling, 11 both.
  - Captures happen only while bit 1 is clear.
  - A capture stores the timer value three edges after the pin change.
- R8: Capture buffer order.
  - Two captures are held at once, and register 3 returns the oldest.
  - Reading register 3 with `rd_en` removes the head.
  - Status bit 8 means not empty and bit 9 means full.
  - A read of an empty buffer returns zero.
- R9: Capture overrun.
  - A capture while the buffer is full sets sticky status bit 10.
  - With control bit 4 set, the new value replaces the second entry; with bit 4 clear, it is dropped.
  - Writing the control word with bit 7 set clears the flag.
  - Captures keep working after an overrun.
- R10: Interrupt output.
  - `irq_o` pulses for one cycle on each compare match, aligned with `match_o`.
  - It also pulses in the cycle in which a capture is stored or rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Read strobe; removes the capture head when the address is 3 |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data, combinational from state |
| tmr_clr | input | 1 | Synchronous timer clear |
| ext_clk | input | 1 | External timer clock, both edges count |
| ext_dir | input | 1 | External count direction, high means up |
| cap_pin | input | 1 | Capture input pin |
| match_o | output | 1 | One-cycle compare match pulse |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The compare path is tried with random start values and random distances up to the compare value, including a distance that crosses the wrap from FFFF to 0000. This separates a real count-onto match from an off-by-one in the match cycle.

Directed patterns then contrast three ways of arriving at the compare value: a timer load, a clear to zero, and counting onto it. Only the last may fire. The external clock is toggled up and down to show that both edges count and that the direction pin is honoured.

Capture is tried in all four edge settings and in compare mode. Random bursts of one to four captures, with the overwrite bit set at random, are checked against a bench model of the two-entry buffer. These bursts tell apart the ordering, the overwrite-versus-drop choice on overrun, and recovery after the flag is cleared.

// File: rtl/evcc_pkg.sv
package evcc_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_TMR  = 2'd1,
        REG_CMP  = 2'd2,
        REG_CAP  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    // bit 5 run, bit 4 overwrite on overrun, bits 3:2 edge, bit 1 compare mode, bit 0 external clock
    typedef struct packed {
        logic      run;
        logic      ovr_ovw;
        edge_sel_e edge_sel;
        logic      cmp_mode;
        logic      ext_clk;
    } ctrl_t;

    typedef enum logic [1:0] {
        CAP_EMPTY = 2'd0,
        CAP_ONE   = 2'd1,
        CAP_TWO   = 2'd2
    } cap_state_e;

    localparam int CTRL_W      = $bits(ctrl_t);
    localparam int OVR_CLR_BIT = 7;
    localparam int ST_NE_BIT   = 8;
    localparam int ST_FULL_BIT = 9;
    localparam int ST_OVR_BIT  = 10;

endpackage

// File: rtl/evcc_sync.sv
module evcc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '0;
            end
            prev_q <= '0;
        end else begin
            stg_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
            prev_q <= stg_q[STAGES-1];
        end
    end

    always_comb begin
        lvl  = stg_q[STAGES-1];
        rise = stg_q[STAGES-1] & ~prev_q;
        fall = ~stg_q[STAGES-1] & prev_q;
    end

endmodule

// File: rtl/evcc_timer.sv
module evcc_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          ext_sel,
    input  logic          ext_edge,
    input  logic          ext_up,
    input  logic          clr,
    input  logic          ld,
    input  logic [TW-1:0] ld_val,
    output logic [TW-1:0] val,
    output logic          moved
);

    logic step;
    logic up;

    always_comb begin
        step = run & (ext_sel ? ext_edge : 1'b1);
        up   = ext_sel ? ext_up : 1'b1;
    end

    // clear has priority over a register load, a load over a count step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val   <= '0;
            moved <= 1'b0;
        end else if (clr) begin
            val   <= '0;
            moved <= 1'b0;
        end else if (ld) begin
            val   <= ld_val;
            moved <= 1'b0;
        end else if (step) begin
            val   <= up ? val + 1'b1 : val - 1'b1;
            moved <= 1'b1;
        end else begin
            moved <= 1'b0;
        end
    end

endmodule

// File: rtl/evcc_compare.sv
module evcc_compare #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          moved,
    input  logic [TW-1:0] val,
    input  logic [TW-1:0] ref_val,
    output logic          hit
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit <= 1'b0;
        end else begin
            hit <= en & moved & (val == ref_val);
        end
    end

endmodule

// File: rtl/evcc_capbuf.sv
module evcc_capbuf
    import evcc_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic          pop,
    input  logic          ovw,
    input  logic          ovr_clr,
    input  logic [TW-1:0] din,
    output logic [TW-1:0] head,
    output logic          nonempty,
    output logic          full,
    output logic          ovr_flag
);

    cap_state_e    st_q, st_d;
    logic [TW-1:0] slot0_q, slot1_q;
    logic          ovr_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CAP_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d    = st_q;
        ovr_hit = 1'b0;
        unique case (st_q)
            CAP_EMPTY: begin
                if (cap) st_d = CAP_ONE;
            end
            CAP_ONE: begin
                if (cap && !pop)      st_d = CAP_TWO;
                else if (!cap && pop) st_d = CAP_EMPTY;
            end
            CAP_TWO: begin
                if (pop && !cap)      st_d = CAP_ONE;
                else if (cap && !pop) ovr_hit = 1'b1;
            end
            default: st_d = CAP_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot0_q <= '0;
            slot1_q <= '0;
        end else begin
            unique case (st_q)
                CAP_EMPTY: begin
                    if (cap) slot0_q <= din;
                end
                CAP_ONE: begin
                    if (cap && pop) slot0_q <= din;
                    else if (cap)   slot1_q <= din;
                end
                CAP_TWO: begin
                    if (pop) begin
                        slot0_q <= slot1_q;
                        if (cap) slot1_q <= din;
                    end else if (cap && ovw) begin
                        slot1_q <= din;
                    end
                end
                default: begin
                    slot0_q <= slot0_q;
                end
            endcase
        end
    end

    // a fresh overrun wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_flag <= 1'b0;
        end else if (ovr_hit) begin
            ovr_flag <= 1'b1;
        end else if (ovr_clr) begin
            ovr_flag <= 1'b0;
        end
    end

    always_comb begin
        nonempty = (st_q != CAP_EMPTY);
        full     = (st_q == CAP_TWO);
        head     = nonempty ? slot0_q : '0;
    end

endmodule

// File: rtl/evcc_top.sv
module evcc_top
    import evcc_pkg::*;
#(
    parameter int TW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [TW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [1:0]    rd_addr,
    output logic [TW-1:0] rd_data,
    input  logic          tmr_clr,
    input  logic          ext_clk,
    input  logic          ext_dir,
    input  logic          cap_pin,
    output logic          match_o,
    output logic          irq_o
);

    localparam int EXT_W = 2;

    ctrl_t         ctrl_q;
    logic [TW-1:0] cmp_q;
    logic [TW-1:0] tmr_val;
    logic          tmr_moved;
    logic          ctl_run, ctl_ext, ctl_cmp;
    logic          wr_ctrl, wr_tmr, wr_cmp, pop_cap, ovr_clr;
    logic [EXT_W-1:0] ext_lvl, ext_rise, ext_fall;
    logic          cap_lvl, cap_rise, cap_fall;
    logic          ext_edge, cap_evt;
    logic [TW-1:0] cap_head;
    logic          st_nonempty, st_full, ovr_flag;
    logic          hit;
    logic          irq_q;
    logic [TW-1:0] stat_word;

    always_comb begin
        wr_ctrl = wr_en && (reg_sel_e'(wr_addr) == REG_CTRL);
        wr_tmr  = wr_en && (reg_sel_e'(wr_addr) == REG_TMR);
        wr_cmp  = wr_en && (reg_sel_e'(wr_addr) == REG_CMP);
        ovr_clr = wr_ctrl && wr_data[OVR_CLR_BIT];
        pop_cap = rd_en && (reg_sel_e'(rd_addr) == REG_CAP);
        ctl_run = ctrl_q.run;
        ctl_ext = ctrl_q.ext_clk;
        ctl_cmp = ctrl_q.cmp_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (wr_cmp)  cmp_q  <= wr_data;
        end
    end

    // bit 0 external clock, bit 1 direction
    evcc_sync #(.W(EXT_W), .STAGES(SYNC_STAGES)) u_ext_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ext_dir, ext_clk}),
        .lvl  (ext_lvl),
        .rise (ext_rise),
        .fall (ext_fall)
    );

    evcc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_cap_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cap_pin),
        .lvl  (cap_lvl),
        .rise (cap_rise),
        .fall (cap_fall)
    );

    always_comb begin
        ext_edge = ext_rise[0] | ext_fall[0];
        unique case (ctrl_q.edge_sel)
            EDGE_NONE: cap_evt = 1'b0;
            EDGE_RISE: cap_evt = cap_rise;
            EDGE_FALL: cap_evt = cap_fall;
            EDGE_BOTH: cap_evt = cap_rise | cap_fall;
            default:   cap_evt = 1'b0;
        endcase
        cap_evt = cap_evt & ~ctl_cmp;
    end

    evcc_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctl_run),
        .ext_sel (ctl_ext),
        .ext_edge(ext_edge),
        .ext_up  (ext_lvl[1]),
        .clr     (tmr_clr),
        .ld      (wr_tmr),
        .ld_val  (wr_data),
        .val     (tmr_val),
        .moved   (tmr_moved)
    );

    evcc_compare #(.TW(TW)) u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ctl_cmp),
        .moved  (tmr_moved),
        .val    (tmr_val),
        .ref_val(cmp_q),
        .hit    (hit)
    );

    evcc_capbuf #(.TW(TW)) u_capbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (cap_evt),
        .pop     (pop_cap),
        .ovw     (ctrl_q.ovr_ovw),
        .ovr_clr (ovr_clr),
        .din     (tmr_val),
        .head    (cap_head),
        .nonempty(st_nonempty),
        .full    (st_full),
        .ovr_flag(ovr_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= (ctl_cmp & tmr_moved & (tmr_val == cmp_q)) | cap_evt;
        end
    end

    always_comb begin
        stat_word                 = '0;
        stat_word[CTRL_W-1:0]     = ctrl_q;
        stat_word[ST_NE_BIT]      = st_nonempty;
        stat_word[ST_FULL_BIT]    = st_full;
        stat_word[ST_OVR_BIT]     = ovr_flag;
        unique case (reg_sel_e'(rd_addr))
            REG_CTRL: rd_data = stat_word;
            REG_TMR:  rd_data = tmr_val;
            REG_CMP:  rd_data = cmp_q;
            REG_CAP:  rd_data = cap_head;
            default:  rd_data = '0;
        endcase
        match_o = hit;
        irq_o   = irq_q;
    end

endmodule

// File: rtl/evcc_checker.sv
module evcc_checker #(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    wr_addr,
    input logic [TW-1:0] wr_data,
    input logic          tmr_clr,
    input logic          match_o,
    input logic          irq_o,
    input logic [TW-1:0] tmr_val,
    input logic          ctl_run,
    input logic          ctl_ext,
    input logic          st_full,
    input logic          st_nonempty,
    input logic          ovr_flag
);

    a_r2_internal_count: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_run && !ctl_ext && !tmr_clr && !(wr_en && wr_addr == 2'd1))
        |=> (tmr_val == TW'($past(tmr_val) + 1'b1)));

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o);

    a_r5_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1) |-> ##2 !match_o);

    a_r6_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_clr |-> ##2 !match_o);

    a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_clr |=> (tmr_val == '0));

    a_r8_full_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        st_full |-> st_nonempty);

    a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !(wr_en && wr_addr == 2'd0 && wr_data[7])) |=> ovr_flag);

    a_r10_irq_with_match: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> irq_o);

endmodule

bind evcc_top evcc_checker #(.TW(TW)) u_evcc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .tmr_clr    (tmr_clr),
    .match_o    (match_o),
    .irq_o      (irq_o),
    .tmr_val    (tmr_val),
    .ctl_run    (ctl_run),
    .ctl_ext    (ctl_ext),
    .st_full    (st_full),
    .st_nonempty(st_nonempty),
    .ovr_flag   (ovr_flag)
);

// File: tb/test_evcc_top.sv
`timescale 1ns/1ps
module test_evcc_top;

    localparam logic [15:0] C_EXT  = 16'h0001;
    localparam logic [15:0] C_CMPM = 16'h0002;
    localparam logic [15:0] C_RISE = 16'h0004;
    localparam logic [15:0] C_FALL = 16'h0008;
    localparam logic [15:0] C_BOTH = 16'h000C;
    localparam logic [15:0] C_OVW  = 16'h0010;
    localparam logic [15:0] C_RUN  = 16'h0020;
    localparam logic [15:0] C_OCLR = 16'h0080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = 2'd0;
    logic [15:0] rd_data;
    logic        tmr_clr = 1'b0;
    logic        ext_clk = 1'b0;
    logic        ext_dir = 1'b1;
    logic        cap_pin = 1'b0;
    logic        match_o;
    logic        irq_o;

    int total = 0;
    int bad   = 0;

    logic [15:0] mq [2];
    int          mcnt;
    bit          movr;

    evcc_top i_evcc_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .tmr_clr(tmr_clr),
        .ext_clk(ext_clk), .ext_dir(ext_dir), .cap_pin(cap_pin),
        .match_o(match_o), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not complete, got=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic pop(output logic [15:0] d);
        rd_addr = 2'd3; rd_en = 1'b1;
        #1 d = rd_data;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // bench model of the two-entry capture buffer
    function automatic void model_push(input logic [15:0] v, input bit ovw);
        if (mcnt < 2) begin
            mq[mcnt] = v;
            mcnt++;
        end else begin
            movr = 1'b1;
            if (ovw) mq[1] = v;
        end
    endfunction

    function automatic logic [15:0] status_exp(input logic [15:0] ctl, input int cnt, input bit ov);
        logic [15:0] s;
        s = ctl & 16'h003F;
        s[8]  = (cnt > 0);
        s[9]  = (cnt == 2);
        s[10] = ov;
        return s;
    endfunction

    // capture helper: requires both-edge selection
    task automatic cap_val(input logic [15:0] v);
        wr(2'd1, v);
        cap_pin = ~cap_pin;
        ticks(3);
    endtask

    task automatic cmp_trial(input logic [15:0] t, input int d);
        logic [15:0] c;
        c = t + 16'(d);
        wr(2'd0, 16'h0000);
        wr(2'd2, c);
        wr(2'd1, t);
        wr(2'd0, C_RUN | C_CMPM);
        for (int k = 1; k <= d + 2; k++) begin
            ticks(1);
            chk($sformatf("R4 match k=%0d d=%0d", k, d), {15'd0, match_o}, {15'd0, (k == d + 1)});
            if (k == d + 1) chk("R10 irq on match", {15'd0, irq_o}, 16'd1);
        end
        wr(2'd0, 16'h0000);
    endtask

    initial begin
        logic [15:0] v;
        logic [15:0] t0;
        void'($urandom(32'd1357));

        // ---- R1 reset state
        ticks(3);
        rst_n = 1'b1;
        ticks(1);
        rd(2'd0, v); chk("R1 ctrl/status", v, 16'h0000);
        rd(2'd1, v); chk("R1 timer", v, 16'h0000);
        rd(2'd2, v); chk("R1 compare", v, 16'h0000);
        rd(2'd3, v); chk("R1 capture", v, 16'h0000);
        chk("R1 match", {15'd0, match_o}, 16'd0);
        chk("R1 irq", {15'd0, irq_o}, 16'd0);

        // ---- R2 internal counting, hold and wrap
        wr(2'd1, 16'h1234);
        wr(2'd0, C_RUN);
        ticks(5);
        rd(2'd1, v); chk("R2 count", v, 16'h1239);
        wr(2'd0, 16'h0000);
        rd(2'd1, t0);
        ticks(4);
        rd(2'd1, v); chk("R2 hold when stopped", v, t0);
        wr(2'd1, 16'hFFFE);
        wr(2'd0, C_RUN);
        ticks(3);
        rd(2'd1, v); chk("R2 wrap", v, 16'h0001);
        wr(2'd0, 16'h0000);

        // ---- R4 directed wrap case, then random distances
        cmp_trial(16'hFFF8, 10);
        for (int i = 0; i < 6; i++) begin
            cmp_trial(16'($urandom), 1 + int'($urandom % 20));
        end

        // ---- R5 load equal to compare, stopped and running
        wr(2'd0, C_CMPM);
        wr(2'd2, 16'h0500);
        wr(2'd1, 16'h0500);
        for (int k = 0; k < 3; k++) begin
            ticks(1); chk("R5 stopped load no match", {15'd0, match_o}, 16'd0);
        end
        wr(2'd0, C_RUN | C_CMPM);
        ticks(3);
        wr(2'd1, 16'h0500);
        for (int k = 0; k < 4; k++) begin
            chk("R5 running load no match", {15'd0, match_o}, 16'd0);
            ticks(1);
        end
        wr(2'd0, 16'h0000);

        // ---- R6 clear wins over write, no match at zero
        wr(2'd0, C_CMPM);
        wr(2'd2, 16'h0000);
        wr(2'd1, 16'h0100);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'h0077; tmr_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; tmr_clr = 1'b0;
        rd(2'd1, v); chk("R6 clear beats write", v, 16'h0000);
        for (int k = 0; k < 3; k++) begin
            chk("R6 clear no match", {15'd0, match_o}, 16'd0);
            ticks(1);
        end
        wr(2'd0, C_RUN | C_CMPM);
        ticks(4);
        tmr_clr = 1'b1; ticks(1); tmr_clr = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R6 running clear no match", {15'd0, match_o}, 16'd0);
            ticks(1);
        end
        wr(2'd0, 16'h0000);

        // ---- R3 external clock, both edges, direction
        ext_dir = 1'b1;
        wr(2'd1, 16'h0010);
        wr(2'd0, C_RUN | C_EXT | C_CMPM);
        ticks(4);
        rd(2'd1, v); chk("R3 no internal ticks", v, 16'h0010);
        ext_clk = 1'b1;
        ticks(2);
        rd(2'd1, v); chk("R3 latency before", v, 16'h0010);
        ticks(1);
        rd(2'd1, v); chk("R3 rising edge up", v, 16'h0011);
        ext_clk = 1'b0; ticks(3);
        rd(2'd1, v); chk("R3 falling edge up", v, 16'h0012);
        ext_clk = 1'b1; ticks(3);
        rd(2'd1, v); chk("R3 third edge up", v, 16'h0013);
        ext_dir = 1'b0;
        ticks(3);
        wr(2'd1, 16'h0002);
        ext_clk = 1'b0; ticks(3);
        rd(2'd1, v); chk("R3 count down", v, 16'h0001);
        chk("R4 no match off target", {15'd0, match_o}, 16'd0);
        ext_clk = 1'b1; ticks(3);
        rd(2'd1, v); chk("R3 count down to zero", v, 16'h0000);
        chk("R4 match not yet", {15'd0, match_o}, 16'd0);
        ticks(1);
        chk("R4 match on counting down onto zero", {15'd0, match_o}, 16'd1);
        chk("R10 irq with ext match", {15'd0, irq_o}, 16'd1);
        ticks(1);
        chk("R4 match one cycle", {15'd0, match_o}, 16'd0);
        wr(2'd0, 16'h0000);
        ext_dir = 1'b1;

        // ---- R7 rising select, R8 ordering, R10 capture irq
        wr(2'd0, C_RISE);
        wr(2'd1, 16'hA001);
        cap_pin = 1'b1;
        ticks(2);
        chk("R7 no capture before sync", {15'd0, irq_o}, 16'd0);
        ticks(1);
        chk("R10 irq on capture", {15'd0, irq_o}, 16'd1);
        rd(2'd0, v); chk("R8 one held", v, status_exp(C_RISE, 1, 0));
        cap_pin = 1'b0; ticks(3);
        rd(2'd0, v); chk("R7 falling ignored on rise", v, status_exp(C_RISE, 1, 0));
        wr(2'd1, 16'hA002);
        cap_pin = 1'b1; ticks(3);
        rd(2'd0, v); chk("R8 full", v, status_exp(C_RISE, 2, 0));
        pop(v); chk("R8 oldest first", v, 16'hA001);
        pop(v); chk("R8 second", v, 16'hA002);
        rd(2'd0, v); chk("R8 empty after reads", v, status_exp(C_RISE, 0, 0));
        pop(v); chk("R8 empty read zero", v, 16'h0000);

        // falling select
        wr(2'd0, C_FALL);
        wr(2'd1, 16'hB001);
        cap_pin = 1'b0; ticks(3);
        cap_pin = 1'b1; ticks(3);
        rd(2'd0, v); chk("R7 falling only", v, status_exp(C_FALL, 1, 0));
        pop(v); chk("R7 falling value", v, 16'hB001);

        // both select
        wr(2'd0, C_BOTH);
        wr(2'd1, 16'hC001);
        cap_pin = 1'b0; ticks(3);
        wr(2'd1, 16'hC002);
        cap_pin = 1'b1; ticks(3);
        pop(v); chk("R7 both edges first", v, 16'hC001);
        pop(v); chk("R7 both edges second", v, 16'hC002);

        // none select, and compare mode
        wr(2'd0, 16'h0000);
        cap_pin = 1'b0; ticks(3);
        cap_pin = 1'b1; ticks(3);
        rd(2'd0, v); chk("R7 none selected", v, status_exp(16'h0000, 0, 0));
        wr(2'd0, C_CMPM | C_BOTH);
        cap_pin = 1'b0; ticks(3);
        rd(2'd0, v); chk("R7 no capture in compare mode", v, status_exp(C_CMPM | C_BOTH, 0, 0));

        // ---- R9 overrun, overwrite and drop
        wr(2'd0, C_BOTH | C_OVW);
        cap_val(16'hD001); cap_val(16'hD002); cap_val(16'hD003);
        rd(2'd0, v); chk("R9 overrun flag", v, status_exp(C_BOTH | C_OVW, 2, 1));
        pop(v); chk("R9 overwrite head kept", v, 16'hD001);
        pop(v); chk("R9 newest overwrote", v, 16'hD003);
        rd(2'd0, v); chk("R9 flag sticky", v, status_exp(C_BOTH | C_OVW, 0, 1));
        wr(2'd0, C_BOTH | C_OCLR);
        rd(2'd0, v); chk("R9 flag cleared", v, status_exp(C_BOTH, 0, 0));
        cap_val(16'hE001); cap_val(16'hE002); cap_val(16'hE003);
        pop(v); chk("R9 drop head", v, 16'hE001);
        pop(v); chk("R9 newest dropped", v, 16'hE002);
        wr(2'd0, C_BOTH | C_OCLR);
        cap_val(16'hE004);
        pop(v); chk("R9 no lockup after overrun", v, 16'hE004);

        // ---- R8/R9 random bursts against the model
        for (int it = 0; it < 8; it++) begin
            bit          ovw;
            int          n;
            logic [15:0] cw;
            ovw  = 1'($urandom);
            n    = 1 + int'($urandom % 4);
            cw   = C_BOTH | (ovw ? C_OVW : 16'h0000);
            mcnt = 0;
            movr = 1'b0;
            wr(2'd0, cw | C_OCLR);
            for (int j = 0; j < n; j++) begin
                logic [15:0] r;
                r = 16'($urandom);
                cap_val(r);
                model_push(r, ovw);
            end
            rd(2'd0, v); chk($sformatf("R9 random status it=%0d", it), v, status_exp(cw, mcnt, movr));
            for (int j = 0; j < mcnt; j++) begin
                pop(v); chk($sformatf("R8 random order it=%0d j=%0d", it, j), v, mq[j]);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule